// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a synchronous host and an external asynchronous static RAM of 32K words of 8 bits. The RAM has active-low select, write-strobe and output-enable pins. The host asks for one word at a time, and the controller turns each request into the pin waveforms the RAM needs. Every RAM timing limit is a parameter in nanoseconds. The controller converts these limits into whole clock cycles when the design is elaborated.

The host presents a request flag, a write/read flag, a 15-bit address and 8 bits of write data. A request is taken only when `ready` is high. A read returns its word on `rd_data` with a one-cycle `rd_valid` strobe. On the memory side the bidirectional data bus is split into an outgoing word, an incoming word and a driver enable, which the pad ring combines.

By default the write strobe runs with output-enable held high, so the shortest write pulse is enough. A parameter can instead hold output-enable low during writes. In that mode the pulse is stretched, and the data driver waits until the RAM has released the bus. A write that directly follows a read is held off for a turnaround gap, so the bus never has two drivers.

Top module: `sram_ctl`

## Requirements
- R1: After reset, mem_cs_n, mem_we_n and mem_oe_n are high, mem_dout_en and rd_valid are low, and ready is high.
- R2: A read holds mem_cs_n low, mem_oe_n low and mem_we_n high for RD_CYC consecutive cycles (2 at the default timing). The address is applied at the edge where mem_cs_n falls.
- R3: rd_data is captured at the edge that ends the last read cycle. rd_valid is high for exactly one cycle, starting RD_CYC edges after the accepting edge, and rd_data keeps its value afterwards.
- R4: With WR_OE_LOW=0, a write holds mem_cs_n and mem_we_n low together for WR_CYC cycles (2 at defaults) with mem_oe_n high. mem_dout_en is high on every cycle of that pulse and is never high outside a write overlap.
- R5: With WR_OE_LOW=1, mem_oe_n stays low through the write, and the pulse lasts max(write pulse, bus release + data setup) cycles (4 at defaults). mem_dout_en stays low for the first bus-release cycles (2) and is high for the remaining data-setup cycles (2).
- R6: mem_addr does not change on any cycle while mem_cs_n and mem_we_n are both low.
- R7: Between the last cycle of a read and the first cycle of a following write there are at least TURN_CYC cycles (2 at defaults) with mem_cs_n high, mem_oe_n high and mem_dout_en low.
- R8: ready is high only while the controller is idle. A request raised while ready is low starts no access and changes no stored word.
- R9: When the next request is already waiting, mem_cs_n goes high for exactly one cycle between read and read, and between write and write.
- R10: A word written to an address is returned by a later read of that address, including addresses 0x0000 and 0x7FFF and the data values 0x00 and 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Host request, taken when ready is high |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address |
| req_wdata | input | 8 | Write data |
| ready | output | 1 | Controller idle, request will be accepted |
| rd_data | output | 8 | Captured read word |
| rd_valid | output | 1 | One-cycle strobe for rd_data |
| mem_addr | output | 15 | RAM address pins |
| mem_cs_n | output | 1 | RAM select, active low |
| mem_we_n | output | 1 | RAM write strobe, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_dout | output | 8 | Data toward the RAM |
| mem_dout_en | output | 1 | Drive enable for mem_dout |
| mem_din | input | 8 | Data from the RAM |

## Verification
The bench's RAM model returns junk until the access time has elapsed. A controller that samples one cycle early therefore returns a wrong word and shows a shorter read window. A write issued directly after a read is measured for its select-high gap and for any driver or output-enable activity in that gap; a missing turnaround shows up there as a gap of one cycle. The stretched-write instance is measured for pulse length, for the delay before the driver turns on, and for the driver-on length, which exposes a driver that turns on too early or a pulse that is not stretched. A request pulsed while the controller is busy must leave the count of select falls unchanged, which catches a controller that accepts work outside idle.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_TURN  = 2'd2,
    ST_WRITE = 2'd3
  } ctl_state_t;

  function automatic int cdiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctl_phase.sv
module sram_ctl_phase #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else            cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sram_ctl_turn.sv
module sram_ctl_turn #(
  parameter int W    = 2,
  parameter int LOAD = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  output logic [W-1:0] left
);
  always_ff @(posedge clk) begin
    if (rst)               left <= '0;
    else if (load)         left <= W'(LOAD);
    else if (left != '0)   left <= left - 1'b1;
  end
endmodule

// File: rtl/sram_ctl_rdcap.sv
module sram_ctl_rdcap #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cap,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= cap;
      if (cap) rd_data <= din;
    end
  end
endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W    = 15,
  parameter int DATA_W    = 8,
  parameter int CLK_NS    = 5,
  parameter int T_ACC_NS  = 10,
  parameter int T_OE_NS   = 6,
  parameter int T_WP_NS   = 9,
  parameter int T_WHZ_NS  = 8,
  parameter int T_DW_NS   = 6,
  parameter int WR_OE_LOW = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dout,
  output logic              mem_dout_en,
  input  logic [DATA_W-1:0] mem_din
);
  // cycle counts derived from nanosecond limits
  localparam int ACC_CYC   = imax(1, cdiv(T_ACC_NS, CLK_NS));
  localparam int OE_CYC    = imax(1, cdiv(T_OE_NS, CLK_NS));
  localparam int WP_CYC    = imax(1, cdiv(T_WP_NS, CLK_NS));
  localparam int DW_CYC    = imax(1, cdiv(T_DW_NS, CLK_NS));
  localparam int WHZ_CYC   = cdiv(T_WHZ_NS, CLK_NS);
  localparam int RD_CYC    = imax(ACC_CYC, OE_CYC);
  localparam int WBASE     = (WR_OE_LOW != 0) ? imax(WP_CYC, WHZ_CYC + DW_CYC)
                                              : imax(WP_CYC, DW_CYC);
  localparam int WR_CYC    = imax(WBASE, ACC_CYC - 1);
  localparam int DRV_START = (WR_OE_LOW != 0) ? WHZ_CYC : 0;
  localparam bit DRV_LATE  = (DRV_START > 0);
  localparam int DRV_AT    = DRV_LATE ? DRV_START - 1 : 0;
  localparam int TURN_CYC  = imax(1, WHZ_CYC);
  localparam int PH_W      = $clog2(imax(RD_CYC, WR_CYC) + 1);
  localparam int TN_W      = $clog2(TURN_CYC + 1);
  localparam logic OE_WR   = (WR_OE_LOW != 0) ? 1'b0 : 1'b1;

  localparam logic [PH_W-1:0] RD_LAST  = PH_W'(RD_CYC - 1);
  localparam logic [PH_W-1:0] WR_LAST  = PH_W'(WR_CYC - 1);
  localparam logic [PH_W-1:0] DRV_STEP = PH_W'(DRV_AT);

  ctl_state_t      st;
  logic [PH_W-1:0] ph;
  logic [TN_W-1:0] turn_left;
  logic            turn_ok;
  logic            start_rd;
  logic            start_wr;
  logic            rd_done;

  assign turn_ok  = (turn_left <= TN_W'(1));
  assign start_rd = (st == ST_IDLE) && req && !req_wr;
  assign start_wr = (((st == ST_IDLE) && req && req_wr) || (st == ST_TURN)) && turn_ok;
  assign rd_done  = (st == ST_READ) && (ph == RD_LAST);

  sram_ctl_phase #(.W(PH_W)) u_phase (
    .clk (clk),
    .rst (rst),
    .clr (start_rd | start_wr),
    .cnt (ph)
  );

  sram_ctl_turn #(.W(TN_W), .LOAD(TURN_CYC)) u_turn (
    .clk  (clk),
    .rst  (rst),
    .load (rd_done),
    .left (turn_left)
  );

  sram_ctl_rdcap #(.DW(DATA_W)) u_rdcap (
    .clk      (clk),
    .rst      (rst),
    .cap      (rd_done),
    .din      (mem_din),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      ready       <= 1'b1;
      mem_addr    <= '0;
      mem_dout    <= '0;
      mem_cs_n    <= 1'b1;
      mem_we_n    <= 1'b1;
      mem_oe_n    <= 1'b1;
      mem_dout_en <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (req) begin
            ready    <= 1'b0;
            mem_addr <= req_addr;   // select is high here, so moving is legal
            if (req_wr) begin
              mem_dout <= req_wdata;
              st       <= ST_TURN;  // overridden below when no gap is owed
            end else begin
              mem_cs_n <= 1'b0;
              mem_oe_n <= 1'b0;
              st       <= ST_READ;
            end
          end
        end
        ST_READ: begin
          if (rd_done) begin
            mem_cs_n <= 1'b1;
            mem_oe_n <= 1'b1;
            ready    <= 1'b1;
            st       <= ST_IDLE;
          end
        end
        ST_TURN: begin
          st <= ST_TURN;
        end
        ST_WRITE: begin
          if (DRV_LATE && (ph == DRV_STEP)) mem_dout_en <= 1'b1;
          if (ph == WR_LAST) begin
            mem_cs_n    <= 1'b1;
            mem_we_n    <= 1'b1;
            mem_oe_n    <= 1'b1;
            mem_dout_en <= 1'b0;
            ready       <= 1'b1;
            st          <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
      if (start_wr) begin
        mem_cs_n    <= 1'b0;
        mem_we_n    <= 1'b0;
        mem_oe_n    <= OE_WR;
        mem_dout_en <= !DRV_LATE;
        st          <= ST_WRITE;
      end
    end
  end

endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk #(
  parameter int ADDR_W    = 15,
  parameter int WR_OE_LOW = 0
) (
  input logic              clk,
  input logic              rst,
  input logic              ready,
  input logic              rd_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_cs_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              mem_dout_en
);
  localparam bit OE_LOW = (WR_OE_LOW != 0);

  a_r6_addr_hold: assert property (@(posedge clk) disable iff (rst)
    (!mem_cs_n && !mem_we_n) |=> (mem_cs_n || mem_we_n || $stable(mem_addr)));

  a_r4_drive_in_write: assert property (@(posedge clk) disable iff (rst)
    mem_dout_en |-> (!mem_cs_n && !mem_we_n));

  a_r5_oe_level_in_write: assert property (@(posedge clk) disable iff (rst)
    (!mem_cs_n && !mem_we_n) |-> (mem_oe_n == !OE_LOW));

  a_r7_no_write_after_read: assert property (@(posedge clk) disable iff (rst)
    (!mem_cs_n && mem_we_n && !mem_oe_n) |=> (mem_we_n && !mem_dout_en));

  a_r3_valid_one_cycle: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);

  a_r8_ready_only_idle: assert property (@(posedge clk) disable iff (rst)
    ready |-> (mem_cs_n && mem_we_n && mem_oe_n && !mem_dout_en));
endmodule

bind sram_ctl sram_ctl_chk #(.ADDR_W(ADDR_W), .WR_OE_LOW(WR_OE_LOW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .ready       (ready),
  .rd_valid    (rd_valid),
  .mem_addr    (mem_addr),
  .mem_cs_n    (mem_cs_n),
  .mem_we_n    (mem_we_n),
  .mem_oe_n    (mem_oe_n),
  .mem_dout_en (mem_dout_en)
);

// File: tb/sim_sram_mem.sv
module sim_sram_mem #(
  parameter int AW   = 15,
  parameter int DW   = 8,
  parameter int NEED = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic          cs_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [DW-1:0] dout,
  input  logic          dout_en,
  output logic [DW-1:0] din
);
  logic [DW-1:0] mem [int];
  int age = 0;
  int we_run = 0, en_run = 0, lead = 0, rd_run = 0, gap = 0;
  bit oe_low = 0, moved = 0, gap_bad = 0, was_rd = 0, cs_prev = 1;
  logic [AW-1:0] w_addr = '0;
  int last_we_len = 0, last_en_len = 0, last_lead = 0, last_rd_len = 0;
  int last_gap = 0, last_rd_gap = 0, cs_falls = 0;
  bit last_oe_low = 0, last_moved = 0, last_gap_bad = 0, gap_after_rd = 0;

  always @* begin
    din = 8'hA5;
    if (!cs_n && we_n && !oe_n && age >= NEED - 1)
      din = mem.exists(int'(addr)) ? mem[int'(addr)] : '0;
  end

  always @(posedge clk) begin
    age <= (!rst && !cs_n && we_n && !oe_n) ? age + 1 : 0;
    if (!rst) begin
      if (!cs_n && !we_n) begin
        if (we_run == 0) begin
          last_gap = gap; gap_after_rd = was_rd; last_gap_bad = gap_bad;
          was_rd = 0; w_addr = addr; moved = 0; en_run = 0; lead = 0; oe_low = 0;
        end
        we_run++;
        if (addr != w_addr) moved = 1;
        if (dout_en) begin en_run++; mem[int'(addr)] = dout; end
        else if (en_run == 0) lead++;
        if (!oe_n) oe_low = 1;
      end else if (we_run > 0) begin
        last_we_len = we_run; last_en_len = en_run; last_lead = lead;
        last_oe_low = oe_low; last_moved = moved; we_run = 0;
      end
      if (!cs_n && we_n && !oe_n) begin
        if (rd_run == 0) begin last_rd_gap = gap; was_rd = 0; end
        rd_run++;
      end else if (rd_run > 0) begin
        last_rd_len = rd_run; rd_run = 0; was_rd = 1;
      end
      if (cs_n) begin
        gap++;
        if (!oe_n || dout_en) gap_bad = 1;
      end else begin
        if (cs_prev) cs_falls++;
        gap = 0; gap_bad = 0;
      end
      cs_prev = cs_n;
    end
  end
endmodule

// File: tb/sim_sram_ctl.sv
module sim_sram_ctl;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1, req = 1'b0, req_wr = 1'b0, sel = 1'b0;
  logic [14:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;

  logic rdy0, vld0, cs0, we0, oe0, den0;
  logic rdy1, vld1, cs1, we1, oe1, den1;
  logic [7:0] rdat0, dout0, din0, rdat1, dout1, din1;
  logic [14:0] maddr0, maddr1;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_ctl u0 (
    .clk(clk), .rst(rst), .req(req & ~sel), .req_wr(req_wr), .req_addr(req_addr),
    .req_wdata(req_wdata), .ready(rdy0), .rd_data(rdat0), .rd_valid(vld0),
    .mem_addr(maddr0), .mem_cs_n(cs0), .mem_we_n(we0), .mem_oe_n(oe0),
    .mem_dout(dout0), .mem_dout_en(den0), .mem_din(din0));

  sram_ctl #(.WR_OE_LOW(1)) u1 (
    .clk(clk), .rst(rst), .req(req & sel), .req_wr(req_wr), .req_addr(req_addr),
    .req_wdata(req_wdata), .ready(rdy1), .rd_data(rdat1), .rd_valid(vld1),
    .mem_addr(maddr1), .mem_cs_n(cs1), .mem_we_n(we1), .mem_oe_n(oe1),
    .mem_dout(dout1), .mem_dout_en(den1), .mem_din(din1));

  sim_sram_mem m0 (.clk(clk), .rst(rst), .addr(maddr0), .cs_n(cs0), .we_n(we0),
    .oe_n(oe0), .dout(dout0), .dout_en(den0), .din(din0));
  sim_sram_mem m1 (.clk(clk), .rst(rst), .addr(maddr1), .cs_n(cs1), .we_n(we1),
    .oe_n(oe1), .dout(dout1), .dout_en(den1), .din(din1));

  logic rdy, vld;
  logic [7:0] rdat;
  assign rdy  = sel ? rdy1 : rdy0;
  assign vld  = sel ? vld1 : vld0;
  assign rdat = sel ? rdat1 : rdat0;

  int n_chk = 0, n_err = 0, lat = 0;
  logic [7:0] got;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge where the access is finished
  task automatic access(input bit wr, input logic [14:0] a, input logic [7:0] d);
    while (!rdy) @(negedge clk);
    req = 1'b1; req_wr = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req = 1'b0; lat = 1;
    if (wr) begin
      while (!rdy) @(negedge clk);
    end else begin
      while (!vld && lat < 64) begin @(negedge clk); lat++; end
      got = rdat;
    end
  endtask

  task automatic settle();
    @(negedge clk); @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 ready", rdy0, 1);  chk("R1 cs_n", cs0, 1);   chk("R1 we_n", we0, 1);
    chk("R1 oe_n", oe0, 1);    chk("R1 dout_en", den0, 0); chk("R1 rd_valid", vld0, 0);
    chk("R1 ready u1", rdy1, 1); chk("R1 cs_n u1", cs1, 1);
  endtask

  task automatic t_write0(input logic [14:0] a, input logic [7:0] d);
    sel = 1'b0;
    access(1'b1, a, d);
    settle();
    chk("R4 pulse length", m0.last_we_len, 2);
    chk("R4 driver cycles", m0.last_en_len, 2);
    chk("R4 oe_n high in write", m0.last_oe_low, 0);
    chk("R6 address held", m0.last_moved, 0);
  endtask

  task automatic t_read0(input logic [14:0] a, input logic [7:0] exp);
    sel = 1'b0;
    access(1'b0, a, 8'h00);
    chk("R3 latency", lat, 3);
    chk("R10 read data", got, exp);
    @(negedge clk);
    chk("R3 valid single", vld0, 0);
    chk("R3 data held", rdat0, exp);
    @(negedge clk);
    chk("R2 read length", m0.last_rd_len, 2);
  endtask

  task automatic t_turnaround();
    sel = 1'b0;
    access(1'b0, 15'h1234, 8'h00);
    access(1'b1, 15'h1234, 8'h5A);
    settle();
    chk("R7 gap length", m0.last_gap, 2);
    chk("R7 gap follows read", m0.gap_after_rd, 1);
    chk("R7 bus quiet in gap", m0.last_gap_bad, 0);
    access(1'b0, 15'h1234, 8'h00);
    chk("R10 data after turnaround", got, 8'h5A);
    access(1'b0, 15'h0000, 8'h00);
    chk("R10 addr 0", got, 8'h3C);
    settle();
    chk("R9 read-read gap", m0.last_rd_gap, 1);
    access(1'b1, 15'h0010, 8'h21);
    access(1'b1, 15'h0011, 8'h22);
    settle();
    chk("R9 write-write gap", m0.last_gap, 1);
    chk("R9 no read before", m0.gap_after_rd, 0);
  endtask

  task automatic t_ignore();
    int f0;
    sel = 1'b0;
    f0 = m0.cs_falls;
    while (!rdy) @(negedge clk);
    req = 1'b1; req_wr = 1'b1; req_addr = 15'h0400; req_wdata = 8'h11;
    @(negedge clk);
    chk("R8 ready low when busy", rdy0, 0);
    req = 1'b1; req_wr = 1'b1; req_addr = 15'h0400; req_wdata = 8'hEE;
    @(negedge clk);
    req = 1'b0;
    settle(); settle();
    chk("R8 busy request dropped", m0.cs_falls - f0, 1);
    t_read0(15'h0400, 8'h11);
  endtask

  task automatic t_stretch();
    sel = 1'b1;
    access(1'b1, 15'h0101, 8'h99);
    settle();
    chk("R5 stretched pulse", m1.last_we_len, 4);
    chk("R5 driver delay", m1.last_lead, 2);
    chk("R5 driver cycles", m1.last_en_len, 2);
    chk("R5 oe_n low in write", m1.last_oe_low, 1);
    chk("R6 address held u1", m1.last_moved, 0);
    access(1'b0, 15'h0101, 8'h00);
    chk("R10 stretched readback", got, 8'h99);
    chk("R3 latency u1", lat, 3);
    settle();
    sel = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_write0(15'h0000, 8'h3C);
    t_write0(15'h7FFF, 8'hFF);
    t_write0(15'h1234, 8'h00);
    t_read0(15'h7FFF, 8'hFF);
    t_read0(15'h1234, 8'h00);
    t_read0(15'h0000, 8'h3C);
    t_turnaround();
    t_ignore();
    t_stretch();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule